// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a 1024-word by 8-bit memory with two independent ports, left and right, each with its own address, active-low chip enable, write enable and output enable, write data, read data and an active-low interrupt output. The two highest addresses double as mailboxes. A port that writes into the other port's mailbox raises that port's interrupt. The owner drops its interrupt by reading its own mailbox. The mailbox words still store data like any other word, so the written byte is the message.

All activity is sampled on the rising clock edge. Read data and both interrupt outputs are registered. The usual flow is: a producer writes a byte to the consumer's mailbox, the consumer sees its interrupt go low, reads the mailbox to fetch the byte, and that same read drops the interrupt.

Top module: `mailbox_dpram`

## Requirements
- R1: Address 0x3FF is the right port's mailbox and 0x3FE is the left port's mailbox. No other address affects either interrupt.
- R2: A left write (cen=0, wen=0) to 0x3FF drives r_irq_n low from the cycle after that clock edge.
- R3: A right write (cen=0, wen=0) to 0x3FE drives l_irq_n low from the cycle after that clock edge.
- R4: A right read (cen=0, oen=0, wen=1) of 0x3FF releases r_irq_n high one cycle later. A left read of 0x3FE releases l_irq_n high one cycle later.
- R5: An access that has cen high, or oen high with wen high, does not clear an interrupt.
- R6: A port that writes its own mailbox leaves its own interrupt unchanged.
- R7: If the opposite port writes a mailbox in the same cycle that its owner reads it, the interrupt ends up asserted.
- R8: While reset is asserted, both interrupt outputs are high and both read data outputs are zero.
- R9: A write stores wdata at the address, including the mailbox addresses. A read returns the stored word on rdata one cycle after the edge. rdata holds its value when the port is not reading.
- R10: Reads and writes to any address other than 0x3FE and 0x3FF leave both interrupts unchanged.
- R11: If both ports write the same address in one cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | 10 | Left address |
| l_cen | input | 1 | Left chip enable, active low |
| l_wen | input | 1 | Left write enable, active low |
| l_oen | input | 1 | Left output enable, active low |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_addr | input | 10 | Right address |
| r_cen | input | 1 | Right chip enable, active low |
| r_wen | input | 1 | Right write enable, active low |
| r_oen | input | 1 | Right output enable, active low |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block passes through exactly one register. An interrupt set, an interrupt clear and read data are therefore all due one cycle after the clock edge that samples the access. The bench applies each access just after a falling edge, so the next rising edge samples it. It then compares the interrupts and read data at the following falling edge, which is the first point where the registered value is stable. Cases where a flag must not change, such as an own-mailbox write, a read with output enable high, or an access to another address, are checked at that same sample point against the value the flag held before the access.

// File: rtl/mailbox_dpram.sv
module mailbox_dpram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_cen,
  input  logic          l_wen,
  input  logic          l_oen,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_cen,
  input  logic          r_wen,
  input  logic          r_oen,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);
  localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic l_flag, r_flag;

  wire l_wr = !l_cen && !l_wen;
  wire r_wr = !r_cen && !r_wen;
  wire l_rd = !l_cen && l_wen && !l_oen;
  wire r_rd = !r_cen && r_wen && !r_oen;

  wire set_r = l_wr && (l_addr == BOX_R);
  wire set_l = r_wr && (r_addr == BOX_L);
  wire clr_r = r_rd && (r_addr == BOX_R);
  wire clr_l = l_rd && (l_addr == BOX_L);

  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= mem[l_addr];
      if (r_rd) r_rdata <= mem[r_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (set_l)      l_flag <= 1'b1;
      else if (clr_l) l_flag <= 1'b0;
      if (set_r)      r_flag <= 1'b1;
      else if (clr_r) r_flag <= 1'b0;
    end
  end

  assign l_irq_n = !l_flag;
  assign r_irq_n = !r_flag;

  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == BOX_R) |=> !r_irq_n);
  a_r3_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && r_addr == BOX_L) |=> !l_irq_n);
  a_r4_right_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && r_addr == BOX_R && !(l_wr && l_addr == BOX_R)) |=> r_irq_n);
  a_r4_left_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == BOX_L && !(r_wr && r_addr == BOX_L)) |=> l_irq_n);
  a_r10_right_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_wr && l_addr == BOX_R) && !(r_rd && r_addr == BOX_R)) |=> $stable(r_irq_n));
  a_r10_left_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(r_wr && r_addr == BOX_L) && !(l_rd && l_addr == BOX_L)) |=> $stable(l_irq_n));
endmodule

// File: tb/tb_mailbox_dpram.sv
module tb_mailbox_dpram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic l_cen = 1, l_wen = 1, l_oen = 1, r_cen = 1, r_wen = 1, r_oen = 1;
  logic [7:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mailbox_dpram dut (.clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_cen(l_cen), .l_wen(l_wen), .l_oen(l_oen), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_addr(r_addr), .r_cen(r_cen), .r_wen(r_wen), .r_oen(r_oen), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq_n(r_irq_n));

  // row: lop, laddr, ldata, rop, raddr, rdata, exp l_irq_n, exp r_irq_n
  // op: 0 idle, 1 write, 2 read, 3 enabled with oen high and wen high
  localparam int N = 13;
  localparam logic [41:0] TBL [N] = '{
    {2'd1, 10'h3FF, 8'hA5, 2'd0, 10'h000, 8'h00, 1'b1, 1'b0}, // R2
    {2'd0, 10'h000, 8'h00, 2'd3, 10'h3FF, 8'h00, 1'b1, 1'b0}, // R5
    {2'd0, 10'h000, 8'h00, 2'd1, 10'h3FF, 8'h11, 1'b1, 1'b0}, // R6
    {2'd0, 10'h000, 8'h00, 2'd2, 10'h3FF, 8'h00, 1'b1, 1'b1}, // R4
    {2'd0, 10'h000, 8'h00, 2'd1, 10'h3FE, 8'h5A, 1'b0, 1'b1}, // R3
    {2'd1, 10'h3FE, 8'h22, 2'd0, 10'h000, 8'h00, 1'b0, 1'b1}, // R6
    {2'd2, 10'h3FD, 8'h00, 2'd0, 10'h000, 8'h00, 1'b0, 1'b1}, // R10
    {2'd0, 10'h000, 8'h00, 2'd1, 10'h3FD, 8'h99, 1'b0, 1'b1}, // R10
    {2'd2, 10'h3FE, 8'h00, 2'd0, 10'h000, 8'h00, 1'b1, 1'b1}, // R4
    {2'd1, 10'h3FF, 8'h77, 2'd2, 10'h3FF, 8'h00, 1'b1, 1'b0}, // R7
    {2'd0, 10'h000, 8'h00, 2'd2, 10'h3FF, 8'h00, 1'b1, 1'b1}, // R4
    {2'd2, 10'h3FE, 8'h00, 2'd1, 10'h3FE, 8'h3C, 1'b0, 1'b1}, // R7
    {2'd2, 10'h3FE, 8'h00, 2'd0, 10'h000, 8'h00, 1'b1, 1'b1}  // R4 R1
  };

  task automatic drive(input logic [1:0] lop, input logic [9:0] la, input logic [7:0] ld,
                       input logic [1:0] rop, input logic [9:0] ra, input logic [7:0] rd);
    l_addr = la; l_wdata = ld; r_addr = ra; r_wdata = rd;
    l_cen = (lop == 0); l_wen = (lop != 1); l_oen = (lop != 2);
    r_cen = (rop == 0); r_wen = (rop != 1); r_oen = (rop != 2);
    @(negedge clk);
    l_cen = 1; l_wen = 1; l_oen = 1; r_cen = 1; r_wen = 1; r_oen = 1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset l_irq_n", {7'd0, l_irq_n}, 8'd1);
    chk("R8 reset r_irq_n", {7'd0, r_irq_n}, 8'd1);
    chk("R8 reset l_rdata", l_rdata, 8'h00);
    chk("R8 reset r_rdata", r_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i][41:40], TBL[i][39:30], TBL[i][29:22],
            TBL[i][21:20], TBL[i][19:10], TBL[i][9:2]);
      chk($sformatf("row %0d l_irq_n (R1-group)", i), {7'd0, l_irq_n}, {7'd0, TBL[i][1]});
      chk($sformatf("row %0d r_irq_n (R1-group)", i), {7'd0, r_irq_n}, {7'd0, TBL[i][0]});
    end

    // R9 mailbox words keep data; left reading 0x3FF does not touch flags
    drive(2'd2, 10'h3FF, 8'h00, 2'd2, 10'h3FE, 8'h00);
    chk("R9 l_rdata 0x3FF", l_rdata, 8'h77);
    chk("R9 r_rdata 0x3FE", r_rdata, 8'h3C);
    chk("R10 r_irq_n after left read", {7'd0, r_irq_n}, 8'd1);
    drive(2'd0, 10'h000, 8'h00, 2'd2, 10'h3FD, 8'h00);
    chk("R9 r_rdata 0x3FD", r_rdata, 8'h99);
    chk("R9 l_rdata holds when idle", l_rdata, 8'h77);

    // R11 same-address write collision
    drive(2'd1, 10'h010, 8'hC1, 2'd1, 10'h010, 8'hD2);
    drive(2'd2, 10'h010, 8'h00, 2'd0, 10'h000, 8'h00);
    chk("R11 left data wins", l_rdata, 8'hC1);

    // R5 read with chip enable high
    drive(2'd0, 10'h000, 8'h00, 2'd1, 10'h3FE, 8'h44);
    chk("R3 set again", {7'd0, l_irq_n}, 8'd0);
    l_addr = 10'h3FE; l_cen = 1; l_wen = 1; l_oen = 0;
    @(negedge clk);
    l_oen = 1;
    chk("R5 cen high no clear", {7'd0, l_irq_n}, 8'd0);

    // R8 reset in the middle of activity
    drive(2'd1, 10'h3FF, 8'h55, 2'd0, 10'h000, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 mid reset l_irq_n", {7'd0, l_irq_n}, 8'd1);
    chk("R8 mid reset r_irq_n", {7'd0, r_irq_n}, 8'd1);
    chk("R8 mid reset l_rdata", l_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule